// File: doc/BRIEF.md
# Bit-Addressed Disk Card Control Register

This block is the control register of a disk expansion card, reached over a serial bit I/O space. The host addresses one control bit at a time: a write carries a single data bit and an address, and the block decodes the address into a bit number and updates that one control output. The outputs drive the rest of the card. They cover card mapping, the motor trigger, wait-state arming, four drive selects, head side, recording density, two ROM page lines, one RAM page line and the clock overlay.

A read at the first bit of the card's window returns one status byte. The byte reports the four drive-present lines and the four configuration switches, and the whole byte is inverted. The block also raises a one-cycle warning when a drive is added to a selection that already holds another drive. Writes take effect on the clock edge at which the strobe is high. Reads are combinational.

Top module: `bitio_ctrl_reg`

## Requirements
- R1: A write changes state only when address bits [15:8] equal the card base 0x11. Any other upper byte leaves every output unchanged.
- R2: The bit number is taken from address bits [4:1]. Address bit 0 and bits [7:5] have no effect on which output a write selects.
- R3: A write with the strobe high updates its target on that clock edge, with the output equal to the data bit. The targets are: bit 0 card select, bit 1 motor strobe, bit 2 wait enable, bit 7 side, bit 10 density, bit 13 RAM page, bit 14 clock overlay.
- R4: Bit 11 writes ROM page bit 0 and bit 15 writes ROM page bit 1. Each write leaves the other page bit alone.
- R5: Bits 4, 5 and 6 set or clear drive mask bits 0, 1 and 2. Bit 8 sets or clears drive mask bit 3. Each drive bit is independent, so several drives may be selected together.
- R6: The warning output is high for exactly one cycle after an edge at which a clear drive bit is set while another drive bit is already set. It is low after every other write.
- R7: Writes to bits 3, 9 and 12 change no output.
- R8: When address bits [15:8] are 0x11 and bits [7:0] are zero, the read byte is the bitwise inverse of {sw[3], sw[2], sw[1], sw[0], 4'b0000}. The switch inputs are sw[3:0].
- R9: The read byte is zero at every other address.
- R10: Reset clears all control outputs, the drive mask and the warning output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Bit I/O address |
| wdata_i | input | 1 | Write data bit |
| wstrobe_i | input | 1 | Write strobe, sampled on the rising edge |
| sw_i | input | 4 | Configuration switches |
| card_sel_o | output | 1 | Card mapped into memory |
| motor_strobe_o | output | 1 | Motor trigger level |
| wait_en_o | output | 1 | Wait-state logic armed |
| drive_sel_o | output | 4 | Drive select mask |
| side_o | output | 1 | Head side |
| dden_o | output | 1 | Density control level |
| rom_page_o | output | 2 | ROM page |
| ram_page_o | output | 1 | RAM page |
| rtc_ovl_o | output | 1 | Clock overlays controller window |
| multi_sel_o | output | 1 | One-cycle multiple-drive warning |
| rdata_o | output | 8 | Read byte |

## Verification
Each control output and the drive mask are due in the same cycle as the clock edge that samples the write strobe. The bench drives a write on a falling edge and drops the strobe on the next falling edge, then reads the outputs at that point, half a cycle after the updating edge. The warning is registered on that same edge and is sampled in that same half cycle, before the following edge clears it. The read byte has no register, so it is checked one nanosecond after the address or switches change.

// File: rtl/bitio_pkg.sv
package bitio_pkg;
  localparam int unsigned N_BITS = 16;
  localparam int unsigned N_DRV  = 4;
  localparam int unsigned IDX_W  = $clog2(N_BITS);

  typedef enum logic [IDX_W-1:0] {
    B_CARD  = 4'd0,  B_MOTOR = 4'd1,  B_WAIT  = 4'd2,  B_NOP3  = 4'd3,
    B_DRV1  = 4'd4,  B_DRV2  = 4'd5,  B_DRV3  = 4'd6,  B_SIDE  = 4'd7,
    B_DRV4  = 4'd8,  B_NOP9  = 4'd9,  B_DDEN  = 4'd10, B_ROM0  = 4'd11,
    B_NOP12 = 4'd12, B_RAM   = 4'd13, B_RTC   = 4'd14, B_ROM1  = 4'd15
  } ctl_bit_e;

  // drive k -> control bit number; drive 4 sits apart from the others
  function automatic int unsigned drv_bit(int unsigned k);
    case (k)
      0:       drv_bit = 4;
      1:       drv_bit = 5;
      2:       drv_bit = 6;
      default: drv_bit = 8;
    endcase
  endfunction
endpackage

// File: rtl/bitio_decode.sv
module bitio_decode
  import bitio_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter logic [7:0]  BASE_HI = 8'h11
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wstrobe_i,
  output logic              hit_o,
  output logic              at_base0_o,
  output logic [N_BITS-1:0] wen_o
);
  logic [IDX_W-1:0] idx;

  assign hit_o      = (addr_i[ADDR_W-1:ADDR_W-8] == BASE_HI);
  assign at_base0_o = hit_o && (addr_i[7:0] == 8'h00);
  assign idx        = addr_i[IDX_W:1];

  for (genvar g = 0; g < N_BITS; g++) begin : g_wen
    assign wen_o[g] = wstrobe_i && hit_o && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/bitio_drive_mask.sv
module bitio_drive_mask
  import bitio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DRV-1:0] drv_wen_i,
  input  logic             wdata_i,
  output logic [N_DRV-1:0] mask_o,
  output logic             multi_o
);
  logic [N_DRV-1:0] set_new;

  always_comb begin
    for (int k = 0; k < N_DRV; k++)
      set_new[k] = drv_wen_i[k] && wdata_i && !mask_o[k];
  end

  for (genvar g = 0; g < N_DRV; g++) begin : g_drv
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           mask_o[g] <= 1'b0;
      else if (drv_wen_i[g]) mask_o[g] <= wdata_i;
    end
  end

  // mask_o[k] is clear for any set_new[k], so |mask_o means another drive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) multi_o <= 1'b0;
    else         multi_o <= (|set_new) && (|mask_o);
  end

  AST_WARN_HAS_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> ($countones(mask_o) >= 2)); // R6
  AST_WARN_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_wen_i == '0) |=> !multi_o); // R6
  for (genvar g = 0; g < N_DRV; g++) begin : g_chk
    AST_DRV_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drv_wen_i[g] |=> (mask_o[g] == $past(wdata_i))); // R5
  end
endmodule

// File: rtl/bitio_read_mux.sv
module bitio_read_mux (
  input  logic       at_base0_i,
  input  logic [3:0] sw_i,
  output logic [7:0] rdata_o
);
  logic [7:0] raw;

  // drive-present lines read as connected (0 before inversion)
  assign raw     = {sw_i[3:2], sw_i[1], sw_i[0], 4'b0000};
  assign rdata_o = at_base0_i ? ~raw : 8'h00;

  always_comb begin
    if (!at_base0_i) AST_READ_ZERO: assert (rdata_o == 8'h00); // R9
    else AST_READ_PRESENT: assert (rdata_o[3:0] == 4'hF); // R8
  end
endmodule

// File: rtl/bitio_ctrl_reg.sv
module bitio_ctrl_reg
  import bitio_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter logic [7:0]  BASE_HI = 8'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  input  logic              wstrobe_i,
  input  logic [3:0]        sw_i,
  output logic              card_sel_o,
  output logic              motor_strobe_o,
  output logic              wait_en_o,
  output logic [N_DRV-1:0]  drive_sel_o,
  output logic              side_o,
  output logic              dden_o,
  output logic [1:0]        rom_page_o,
  output logic              ram_page_o,
  output logic              rtc_ovl_o,
  output logic              multi_sel_o,
  output logic [7:0]        rdata_o
);
  logic              hit, at_base0;
  logic [N_BITS-1:0] wen;
  logic [N_DRV-1:0]  drv_wen;
  logic              dead_wr;
  logic [12:0]       state_vec;

  bitio_decode #(.ADDR_W(ADDR_W), .BASE_HI(BASE_HI)) u_dec (
    .addr_i(addr_i), .wstrobe_i(wstrobe_i),
    .hit_o(hit), .at_base0_o(at_base0), .wen_o(wen)
  );

  for (genvar g = 0; g < N_DRV; g++) begin : g_dmap
    assign drv_wen[g] = wen[drv_bit(g)];
  end

  bitio_drive_mask u_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .drv_wen_i(drv_wen), .wdata_i(wdata_i),
    .mask_o(drive_sel_o), .multi_o(multi_sel_o)
  );

  bitio_read_mux u_rd (.at_base0_i(at_base0), .sw_i(sw_i), .rdata_o(rdata_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      card_sel_o     <= 1'b0;
      motor_strobe_o <= 1'b0;
      wait_en_o      <= 1'b0;
      side_o         <= 1'b0;
      dden_o         <= 1'b0;
      rom_page_o     <= 2'b00;
      ram_page_o     <= 1'b0;
      rtc_ovl_o      <= 1'b0;
    end else begin
      if (wen[B_CARD])  card_sel_o     <= wdata_i;
      if (wen[B_MOTOR]) motor_strobe_o <= wdata_i;
      if (wen[B_WAIT])  wait_en_o      <= wdata_i;
      if (wen[B_SIDE])  side_o         <= wdata_i;
      if (wen[B_DDEN])  dden_o         <= wdata_i;
      if (wen[B_ROM0])  rom_page_o[0]  <= wdata_i;
      if (wen[B_ROM1])  rom_page_o[1]  <= wdata_i;
      if (wen[B_RAM])   ram_page_o     <= wdata_i;
      if (wen[B_RTC])   rtc_ovl_o      <= wdata_i;
    end
  end

  assign dead_wr   = wen[B_NOP3] | wen[B_NOP9] | wen[B_NOP12];
  assign state_vec = {card_sel_o, motor_strobe_o, wait_en_o, drive_sel_o, side_o,
                      dden_o, rom_page_o, ram_page_o, rtc_ovl_o};

  AST_OUTSIDE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wstrobe_i && !hit) |=> $stable(state_vec)); // R1
  AST_DEAD_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_wr |=> $stable(state_vec)); // R7
  AST_CARD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wstrobe_i && hit && addr_i[4:1] == 4'd0) |=> (card_sel_o == $past(wdata_i))); // R3
  AST_ROM_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wstrobe_i && hit && addr_i[4:1] == 4'd11) |=> $stable(rom_page_o[1])); // R4
endmodule

// File: tb/bitio_ctrl_reg_tb.sv
module bitio_ctrl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0;
  logic        wdata = 1'b0, wstrobe = 1'b0;
  logic [3:0]  sw = 4'h0;
  logic        card, motor, waite, side, dden, ram, rtc, multi;
  logic [3:0]  drv;
  logic [1:0]  rom;
  logic [7:0]  rdata;
  logic        last_warn;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  bitio_ctrl_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wstrobe_i(wstrobe),
    .sw_i(sw), .card_sel_o(card), .motor_strobe_o(motor), .wait_en_o(waite),
    .drive_sel_o(drv), .side_o(side), .dden_o(dden), .rom_page_o(rom),
    .ram_page_o(ram), .rtc_ovl_o(rtc), .multi_sel_o(multi), .rdata_o(rdata)
  );

  function automatic logic [12:0] snap();
    return {card, motor, waite, drv, side, dden, rom, ram, rtc};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_raw(logic [15:0] a, logic d);
    @(negedge clk);
    addr = a; wdata = d; wstrobe = 1'b1;
    @(negedge clk);
    wstrobe = 1'b0;
    last_warn = multi;
  endtask

  task automatic wr_bit(int b, logic d);
    wr_raw(16'h1100 | 16'(b << 1), d);
  endtask

  task automatic t_reset();
    check("R10 state", {3'b0, snap()}, 16'h0);
    check("R10 warn", {15'b0, multi}, 16'h0);
  endtask

  task automatic t_singles();
    wr_bit(0, 1);  check("R3 card", {15'b0, card}, 16'h1);
    wr_bit(1, 1);  check("R3 motor", {15'b0, motor}, 16'h1);
    wr_bit(7, 1);  check("R3 side", {15'b0, side}, 16'h1);
    wr_bit(10, 1); check("R3 dden", {15'b0, dden}, 16'h1);
    wr_bit(13, 1); check("R3 ram", {15'b0, ram}, 16'h1);
    wr_bit(1, 0);  check("R3 motor clr", {15'b0, motor}, 16'h0);
    check("R3 others kept", {12'b0, card, side, dden, ram}, 16'hF);
  endtask

  task automatic t_rom_page();
    wr_bit(11, 1); check("R4 rom01", {14'b0, rom}, 16'h1);
    wr_bit(15, 1); check("R4 rom11", {14'b0, rom}, 16'h3);
    wr_bit(11, 0); check("R4 rom10", {14'b0, rom}, 16'h2);
  endtask

  task automatic t_drives();
    wr_bit(4, 1); check("R5 drv1", {12'b0, drv}, 16'h1);
    check("R6 first no warn", {15'b0, last_warn}, 16'h0);
    wr_bit(8, 1); check("R5 drv4", {12'b0, drv}, 16'h9);
    check("R6 warn", {15'b0, last_warn}, 16'h1);
    @(negedge clk); check("R6 one cycle", {15'b0, multi}, 16'h0);
    wr_bit(8, 1); check("R6 reset no warn", {15'b0, last_warn}, 16'h0);
    wr_bit(6, 1); check("R5 drv3", {12'b0, drv}, 16'hD);
    wr_bit(4, 0); check("R5 clr drv1", {12'b0, drv}, 16'hC);
    wr_bit(5, 1); check("R5 drv2", {12'b0, drv}, 16'hE);
  endtask

  task automatic t_addressing();
    logic [12:0] s;
    s = snap();
    wr_raw(16'h1200 | 16'(2 << 1), 1'b1);
    wr_raw(16'h0100 | 16'(14 << 1), 1'b1);
    check("R1 outside base", {3'b0, snap()}, {3'b0, s});
    wr_raw(16'h1100 | 16'(2 << 1) | 16'h1, 1'b1);
    check("R2 odd addr wait", {15'b0, waite}, 16'h1);
    wr_raw(16'h11E0 | 16'(14 << 1), 1'b1);
    check("R2 high bits rtc", {15'b0, rtc}, 16'h1);
  endtask

  task automatic t_dead();
    logic [12:0] s;
    s = snap();
    wr_bit(3, 1); wr_bit(9, 1); wr_bit(12, 1); wr_bit(12, 0);
    check("R7 dead bits", {3'b0, snap()}, {3'b0, s});
  endtask

  task automatic t_read();
    addr = 16'h1100; sw = 4'b1001; #1;
    check("R8 read a", {8'b0, rdata}, 16'h006F);
    sw = 4'b0110; #1;
    check("R8 read b", {8'b0, rdata}, 16'h009F);
    sw = 4'b0000; #1;
    check("R8 read c", {8'b0, rdata}, 16'h00FF);
    addr = 16'h1102; #1;
    check("R9 other offset", {8'b0, rdata}, 16'h0);
    addr = 16'h1200; #1;
    check("R9 outside", {8'b0, rdata}, 16'h0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk); rst_n = 1'b0; #1;
    check("R10 mid reset", {3'b0, snap()}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_singles();
    t_rom_page();
    t_drives();
    t_addressing();
    t_dead();
    t_read();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule